// File: doc/BRIEF.md
# Periodic Correlator Snapshot Collector

The collector sits between a multi-channel correlator register file and a host link. On a fixed tick, shorter than the correlator's accumulation period, it reads four status words and then four accumulation registers from every channel. It does this without looking at the per-channel new-data flags, so no accumulation result can slip between two snapshots. The consumer decides afterwards which values are fresh. Each snapshot is written into a frame buffer with two halves. Four snapshots fill one half, together with a measurement region and one timestamp byte per snapshot.

After the fourth snapshot of a frame, the collector reads the measurement region. A measurement epoch (TIC) seen during the frame selects a full read of eight measurement registers per channel. Without one, only each channel's epoch-check register is read, and the other measurement words keep their old contents. When that work ends, the halves swap and a one-cycle frame-ready pulse tells the link side which half it may now drain through its own read port. The collector meanwhile refills the other half.

Top module: `ssc_collector`

## Requirements
- R1: A snapshot starts on every period of TICK_CYCLES clocks. Its timestamp byte is the low 8 bits of a free-running counter that starts at 0 after reset and increments every clock. The byte is sampled in the first cycle of the snapshot. Snapshot g (counted from 0 since reset) therefore carries ((g+1)*TICK_CYCLES) mod 256. Snapshot k of a frame stores its byte in word 160+k/2: the low byte when k is even, the high byte when k is odd.
- R2: Every snapshot reads, in this order, the status registers at addresses 0,1,2,3, then for each channel c from 0 to 5 its accumulation registers at 0x10+16c+j, for j from 0 to 3. These reads happen regardless of any data value.
- R3: Data is 16 bits per word. Status read j goes to word 28k+j of the fill half. Accumulation read (c,j) goes to word 28k+4+4c+j.
- R4: A frame holds 4 snapshots. After the last read of snapshot 3, including its measurement reads, frame_ready_o is high for exactly one cycle. In that same cycle drain_half_o names the half just filled, and drain_half_o changes at no other time. The first frame fills half 0.
- R5: In a frame with a TIC, measurement register m of channel c (address 0x10+16c+4+m, m from 0 to 7) is read into word 112+8c+m.
- R6: In a frame without a TIC, only register m=7 of each channel is read, into word 112+8c+7. The other measurement words of that half keep their earlier contents.
- R7: A TIC pulse belongs to the frame whose measurement decision is the next one to happen. The decision is taken at the last accumulation read of snapshot 3, and a pulse in that same cycle counts. Taking the decision clears the latched TIC.
- R8: A register read holds reg_req_o high with a stable reg_addr_o until reg_ack_i. The data is taken in the acknowledge cycle.
- R9: The link port returns word link_addr_i of half link_half_i one cycle later. Filling never writes into the half named by drain_half_o.
- R10: During reset, reg_req_o and frame_ready_o are low and drain_half_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tic_i | input | 1 | Measurement epoch pulse |
| reg_req_o | output | 1 | Register read request |
| reg_addr_o | output | 8 | Correlator register address |
| reg_ack_i | input | 1 | Read acknowledge, data valid |
| reg_data_i | input | 16 | Read data |
| link_half_i | input | 1 | Half selected for link read |
| link_addr_i | input | 8 | Word address for link read |
| link_data_o | output | 16 | Link read data, one cycle latency |
| frame_ready_o | output | 1 | One-cycle pulse: a frame is complete |
| drain_half_o | output | 1 | Half that the link may drain |

## Verification
Two events can fall in the same cycle. The first is link reads from the drained half while acknowledged correlator reads write the other half. The bench provokes this by draining a whole frame during the next frame's fill, with random acknowledge latency, and judges it by comparing every word against a byte-level model of both halves. The second is TIC arrival against the swap and the measurement decision. TIC pulses come at random delays after frame_ready_o, including twice in one frame. The bench judges this by the measurement region contents and by stale words surviving in epoch-check-only frames.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int NUM_CH      = 6;
  localparam int SNAPS       = 4;
  localparam int STAT_REGS   = 4;
  localparam int ACC_REGS    = 4;
  localparam int MEAS_REGS   = 8;
  localparam int DW          = 16;
  localparam int RAW         = 8;
  localparam int STAT_BASE   = 0;
  localparam int CH_BASE     = 16;
  localparam int CH_STRIDE   = 16;
  localparam int SNAP_WORDS  = STAT_REGS + NUM_CH * ACC_REGS;
  localparam int MEAS_W0     = SNAPS * SNAP_WORDS;
  localparam int TS_W0       = MEAS_W0 + NUM_CH * MEAS_REGS;
  localparam int FRAME_WORDS = 176;
  localparam int WAW         = $clog2(FRAME_WORDS);
  localparam int SNAP_BITS   = $clog2(SNAPS);
  localparam int IDX_W       = $clog2(NUM_CH * MEAS_REGS + 1);

  typedef enum logic [1:0] {PH_STAT, PH_ACC, PH_MEAS} phase_t;

  function automatic logic [RAW-1:0] status_addr(input int j);
    return RAW'(STAT_BASE + j);
  endfunction

  function automatic logic [RAW-1:0] acc_addr(input int c, input int j);
    return RAW'(CH_BASE + c * CH_STRIDE + j);
  endfunction

  function automatic logic [RAW-1:0] meas_addr(input int c, input int m);
    return RAW'(CH_BASE + c * CH_STRIDE + ACC_REGS + m);
  endfunction

  function automatic logic [WAW-1:0] snap_word(input int k, input int j);
    return WAW'(k * SNAP_WORDS + j);
  endfunction

  function automatic logic [WAW-1:0] meas_word(input int c, input int m);
    return WAW'(MEAS_W0 + c * MEAS_REGS + m);
  endfunction

  function automatic logic [WAW-1:0] ts_word(input int k);
    return WAW'(TS_W0 + k / 2);
  endfunction
endpackage

// File: rtl/ssc_tick_gen.sv
module ssc_tick_gen #(
  parameter int TICK_CYCLES = 900,
  parameter int TS_BITS     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       tick_o,
  output logic [7:0] ts_byte_o
);
  localparam int CNT_W = $clog2(TICK_CYCLES);

  logic [CNT_W-1:0]   cnt_q;
  logic [TS_BITS-1:0] ts_q;

  assign tick_o    = (cnt_q == CNT_W'(TICK_CYCLES - 1));
  assign ts_byte_o = ts_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ts_q  <= '0;
    end else begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      ts_q  <= ts_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
  import ssc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic [7:0]          ts_byte_i,
  input  logic                tic_i,
  output logic                reg_req_o,
  output logic [RAW-1:0]      reg_addr_o,
  input  logic                reg_ack_i,
  input  logic [DW-1:0]       reg_data_i,
  output logic                ram_we_o,
  output logic [1:0]          ram_be_o,
  output logic [WAW-1:0]      ram_waddr_o,
  output logic [DW-1:0]       ram_wdata_o,
  output logic                fill_half_o,
  output logic                frame_done_o,
  output logic                meas_decide_o,
  output logic                full_meas_o
);
  logic                 busy_q, pending_q, tic_lat_q, full_meas_q, fill_q;
  logic [SNAP_BITS-1:0] snap_q;
  logic [IDX_W-1:0]     idx_q;
  phase_t               phase_q;

  logic           start, ack_fire, last, snap_is_last;
  logic [RAW-1:0] cur_addr;
  logic [WAW-1:0] cur_word;
  int             i, c, m, k;

  assign start        = !busy_q && pending_q;
  assign ack_fire     = busy_q && reg_ack_i;
  assign snap_is_last = (snap_q == SNAP_BITS'(SNAPS - 1));

  always_comb begin
    i = int'(idx_q);
    k = int'(snap_q);
    c = 0;
    m = 0;
    cur_addr = '0;
    cur_word = '0;
    last = 1'b0;
    unique case (phase_q)
      PH_STAT: begin
        cur_addr = status_addr(i);
        cur_word = snap_word(k, i);
        last     = (i == STAT_REGS - 1);
      end
      PH_ACC: begin
        c        = i / ACC_REGS;
        m        = i % ACC_REGS;
        cur_addr = acc_addr(c, m);
        cur_word = snap_word(k, STAT_REGS + i);
        last     = (i == NUM_CH * ACC_REGS - 1);
      end
      default: begin
        if (full_meas_q) begin
          c    = i / MEAS_REGS;
          m    = i % MEAS_REGS;
          last = (i == NUM_CH * MEAS_REGS - 1);
        end else begin
          c    = i;
          m    = MEAS_REGS - 1;
          last = (i == NUM_CH - 1);
        end
        cur_addr = meas_addr(c, m);
        cur_word = meas_word(c, m);
      end
    endcase
  end

  assign meas_decide_o = ack_fire && last && (phase_q == PH_ACC) && snap_is_last;
  assign frame_done_o  = ack_fire && last && (phase_q == PH_MEAS);
  assign reg_req_o     = busy_q;
  assign reg_addr_o    = cur_addr;
  assign fill_half_o   = fill_q;
  assign full_meas_o   = full_meas_q;

  always_comb begin
    if (start) begin
      ram_we_o    = 1'b1;
      ram_be_o    = snap_q[0] ? 2'b10 : 2'b01;
      ram_waddr_o = ts_word(k);
      ram_wdata_o = {ts_byte_i, ts_byte_i};
    end else begin
      ram_we_o    = ack_fire;
      ram_be_o    = 2'b11;
      ram_waddr_o = cur_word;
      ram_wdata_o = reg_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      pending_q   <= 1'b0;
      tic_lat_q   <= 1'b0;
      full_meas_q <= 1'b0;
      fill_q      <= 1'b0;
      snap_q      <= '0;
      idx_q       <= '0;
      phase_q     <= PH_STAT;
    end else begin
      if (start)       pending_q <= tick_i;
      else if (tick_i) pending_q <= 1'b1;

      if (meas_decide_o) tic_lat_q <= 1'b0;
      else if (tic_i)    tic_lat_q <= 1'b1;

      if (start) begin
        busy_q  <= 1'b1;
        phase_q <= PH_STAT;
        idx_q   <= '0;
      end else if (ack_fire) begin
        if (!last) begin
          idx_q <= idx_q + 1'b1;
        end else begin
          idx_q <= '0;
          unique case (phase_q)
            PH_STAT: phase_q <= PH_ACC;
            PH_ACC: begin
              if (snap_is_last) begin
                phase_q     <= PH_MEAS;
                full_meas_q <= tic_lat_q | tic_i;
              end else begin
                busy_q <= 1'b0;
                snap_q <= snap_q + 1'b1;
              end
            end
            default: begin
              busy_q <= 1'b0;
              snap_q <= '0;
              fill_q <= ~fill_q;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ssc_frame_ram.sv
module ssc_frame_ram
  import ssc_pkg::*;
(
  input  logic           clk,
  input  logic           we_i,
  input  logic [1:0]     be_i,
  input  logic           wr_half_i,
  input  logic [WAW-1:0] waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           rd_half_i,
  input  logic [WAW-1:0] raddr_i,
  output logic [DW-1:0]  rdata_o
);
  localparam int DEPTH = 2 * FRAME_WORDS;
  localparam int DAW   = $clog2(DEPTH);

  logic [7:0] lo_mem [DEPTH];
  logic [7:0] hi_mem [DEPTH];
  logic [DAW-1:0] wi, ri;

  function automatic logic [DAW-1:0] flat(input logic half, input logic [WAW-1:0] a);
    return DAW'(a) + (half ? DAW'(FRAME_WORDS) : DAW'(0));
  endfunction

  assign wi = flat(wr_half_i, waddr_i);
  assign ri = flat(rd_half_i, raddr_i);

  always_ff @(posedge clk) begin
    if (we_i && be_i[0]) lo_mem[wi] <= wdata_i[7:0];
    if (we_i && be_i[1]) hi_mem[wi] <= wdata_i[15:8];
    rdata_o <= {hi_mem[ri], lo_mem[ri]};
  end
endmodule

// File: rtl/ssc_collector.sv
module ssc_collector
  import ssc_pkg::*;
#(
  parameter int TICK_CYCLES = 900,
  parameter int TS_BITS     = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tic_i,
  output logic           reg_req_o,
  output logic [RAW-1:0] reg_addr_o,
  input  logic           reg_ack_i,
  input  logic [DW-1:0]  reg_data_i,
  input  logic           link_half_i,
  input  logic [WAW-1:0] link_addr_i,
  output logic [DW-1:0]  link_data_o,
  output logic           frame_ready_o,
  output logic           drain_half_o
);
  logic           tick;
  logic [7:0]     ts_byte;
  logic           ram_we;
  logic [1:0]     ram_be;
  logic [WAW-1:0] ram_waddr;
  logic [DW-1:0]  ram_wdata;
  logic           ram_wr_half;
  logic           frame_done;
  logic           meas_decide;
  logic           full_meas;
  logic           ready_q, drain_q;

  ssc_tick_gen #(.TICK_CYCLES(TICK_CYCLES), .TS_BITS(TS_BITS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick), .ts_byte_o(ts_byte)
  );

  ssc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ts_byte_i(ts_byte), .tic_i(tic_i),
    .reg_req_o(reg_req_o), .reg_addr_o(reg_addr_o), .reg_ack_i(reg_ack_i),
    .reg_data_i(reg_data_i), .ram_we_o(ram_we), .ram_be_o(ram_be),
    .ram_waddr_o(ram_waddr), .ram_wdata_o(ram_wdata), .fill_half_o(ram_wr_half),
    .frame_done_o(frame_done), .meas_decide_o(meas_decide), .full_meas_o(full_meas)
  );

  ssc_frame_ram u_ram (
    .clk(clk), .we_i(ram_we), .be_i(ram_be), .wr_half_i(ram_wr_half),
    .waddr_i(ram_waddr), .wdata_i(ram_wdata), .rd_half_i(link_half_i),
    .raddr_i(link_addr_i), .rdata_o(link_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      drain_q <= 1'b1;
    end else begin
      ready_q <= frame_done;
      if (frame_done) drain_q <= ram_wr_half;
    end
  end

  assign frame_ready_o = ready_q;
  assign drain_half_o  = drain_q;
endmodule

// File: rtl/ssc_collector_chk.sv
module ssc_collector_chk
  import ssc_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           tic_i,
  input logic           reg_req_o,
  input logic           reg_ack_i,
  input logic [RAW-1:0] reg_addr_o,
  input logic           frame_ready_o,
  input logic           drain_half_o,
  input logic           ram_we,
  input logic           ram_wr_half,
  input logic           meas_decide,
  input logic           full_meas
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o));

  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready_o |=> !frame_ready_o);

  // R4
  half_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready_o |-> drain_half_o != $past(drain_half_o));

  // R4
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ready_o |-> $stable(drain_half_o));

  // R9
  fill_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_wr_half != drain_half_o);

  // R7
  tic_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_decide && tic_i |=> full_meas);
endmodule

bind ssc_collector ssc_collector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tic_i(tic_i), .reg_req_o(reg_req_o),
  .reg_ack_i(reg_ack_i), .reg_addr_o(reg_addr_o), .frame_ready_o(frame_ready_o),
  .drain_half_o(drain_half_o), .ram_we(ram_we), .ram_wr_half(ram_wr_half),
  .meas_decide(meas_decide), .full_meas(full_meas)
);

// File: tb/test_ssc_collector.sv
module test_ssc_collector;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 400;
  localparam int NF = 8;
  localparam int FW = 176;

  logic clk = 1'b0, rst_n = 1'b0, tic = 1'b0;
  logic reg_req, reg_ack = 1'b0;
  logic [7:0] reg_addr;
  logic [15:0] reg_data = '0;
  logic link_half = 1'b0;
  logic [7:0] link_addr = '0;
  logic [15:0] link_data;
  logic frame_ready, drain_half;

  int checks = 0, errors = 0;
  int snap_id = -1, pos = 0, wait_n = 0;
  bit pend = 0;
  logic [7:0] pend_addr = '0;

  logic [7:0] mlo [2][FW];
  logic [7:0] mhi [2][FW];
  bit vlo [2][FW];
  bit vhi [2][FW];
  bit tic_plan [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  ssc_collector #(.TICK_CYCLES(TICK)) i_ssc_collector (
    .clk(clk), .rst_n(rst_n), .tic_i(tic), .reg_req_o(reg_req), .reg_addr_o(reg_addr),
    .reg_ack_i(reg_ack), .reg_data_i(reg_data), .link_half_i(link_half),
    .link_addr_i(link_addr), .link_data_o(link_data), .frame_ready_o(frame_ready),
    .drain_half_o(drain_half)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] exp_addr(input int p);
    if (p < 4) return 8'(p);
    return 8'(16 + ((p - 4) / 4) * 16 + (p - 4) % 4);
  endfunction

  // correlator register slave with random acknowledge latency
  initial begin
    forever begin
      @(negedge clk);
      reg_ack = 1'b0;
      if (rst_n && reg_req) begin
        if (pend) chk(reg_addr == pend_addr, "R8", reg_addr, pend_addr);
        if (wait_n == 0) begin
          if (reg_addr == 8'h00) begin snap_id++; pos = 0; end
          if (pos < 28) chk(reg_addr == exp_addr(pos), "R2", reg_addr, exp_addr(pos));
          pos++;
          reg_ack = 1'b1;
          reg_data = {8'(snap_id), reg_addr};
          wait_n = int'($urandom % 3);
          pend = 0;
        end else begin
          wait_n--;
          pend = 1;
          pend_addr = reg_addr;
        end
      end else if (rst_n && pend) begin
        chk(1'b0, "R8", 0, 1);
        pend = 0;
      end
    end
  end

  task automatic put(input int h, input int w, input logic [15:0] d);
    mlo[h][w] = d[7:0]; mhi[h][w] = d[15:8];
    vlo[h][w] = 1; vhi[h][w] = 1;
  endtask

  task automatic model_frame(input int f, input int h, input bit full);
    for (int k = 0; k < 4; k++) begin
      int g = 4 * f + k;
      logic [7:0] ts = 8'((g + 1) * TICK);
      for (int j = 0; j < 4; j++) put(h, 28 * k + j, {8'(g), 8'(j)});
      for (int c = 0; c < 6; c++)
        for (int j = 0; j < 4; j++)
          put(h, 28 * k + 4 + 4 * c + j, {8'(g), 8'(16 + 16 * c + j)});
      if (k % 2 == 0) begin mlo[h][160 + k/2] = ts; vlo[h][160 + k/2] = 1; end
      else begin mhi[h][160 + k/2] = ts; vhi[h][160 + k/2] = 1; end
    end
    for (int c = 0; c < 6; c++)
      for (int m = 0; m < 8; m++)
        if (full || m == 7) put(h, 112 + 8 * c + m, {8'(4 * f + 3), 8'(16 + 16 * c + 4 + m)});
  endtask

  function automatic string tag_of(input int w, input bit full);
    if (w < 112) return "R3";
    if (w < 160) return full ? "R5" : "R6";
    return "R1";
  endfunction

  task automatic drain(input int h, input bit full);
    link_half = h[0];
    for (int w = 0; w < FW; w++) begin
      link_addr = 8'(w);
      @(negedge clk);
      if (vlo[h][w]) chk(link_data[7:0] == mlo[h][w], tag_of(w, full), link_data[7:0], mlo[h][w]);
      if (vhi[h][w]) chk(link_data[15:8] == mhi[h][w], tag_of(w, full), link_data[15:8], mhi[h][w]);
    end
  endtask

  task automatic pulse_tic(input int dly);
    repeat (dly) @(negedge clk);
    tic = 1'b1;
    @(negedge clk);
    tic = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int seed_val;
    seed_val = int'($urandom(32'd20240611));
    for (int h = 0; h < 2; h++)
      for (int w = 0; w < FW; w++) begin vlo[h][w] = 0; vhi[h][w] = 0; end
    tic_plan[0] = 0; tic_plan[1] = 1; tic_plan[2] = 1; tic_plan[3] = 0;
    tic_plan[4] = 1; tic_plan[5] = 0;
    for (int f = 6; f < NF; f++) tic_plan[f] = bit'($urandom % 2);

    repeat (4) @(negedge clk);
    chk(reg_req == 1'b0, "R10", reg_req, 0);
    chk(frame_ready == 1'b0, "R10", frame_ready, 0);
    chk(drain_half == 1'b1, "R10", drain_half, 1);
    rst_n = 1'b1;

    for (int f = 0; f < NF; f++) begin
      while (!frame_ready) @(negedge clk);
      chk(drain_half == 1'(f % 2), "R4", drain_half, f % 2);
      if (f + 1 < NF && tic_plan[f + 1]) begin
        fork pulse_tic(int'($urandom % 700)); join_none
        if (f + 1 == 4) begin fork pulse_tic(750); join_none end
      end
      model_frame(f, f % 2, tic_plan[f]);
      @(negedge clk);
      chk(frame_ready == 1'b0, "R4", frame_ready, 0);
      chk(drain_half == 1'(f % 2), "R4", drain_half, f % 2);
      drain(f % 2, tic_plan[f]);
      if (tic_plan[f]) begin
        link_addr = 8'd112;
        @(negedge clk);
        chk(link_data == {8'(4 * f + 3), 8'h14}, "R7", link_data, {8'(4 * f + 3), 8'h14});
      end
      link_addr = 8'd0;
      repeat (20) @(negedge clk);
      chk(link_data == {8'(4 * f), 8'h00}, "R9", link_data, {8'(4 * f), 8'h00});
    end
    finish_run();
  end
endmodule